// File: doc/BRIEF.md
# Programmable One-Shot / Periodic Tick Timer

This block is a down-counting event timer paced by an external tick strobe, typically one pulse per microsecond. Software programs a single control word that holds an enable flag, a repeat flag and a 29-bit count. To get an interval of N ticks, software loads N-1. A request for zero or one tick loads 0, which expires on the next tick. When the counter is already at zero and a tick arrives, the timer expires and raises an active-high level interrupt.

In one-shot mode the expiry also turns the enable flag off, and the counter then stays at zero. In repeat mode the counter reloads the programmed count and keeps firing. For example, a count of 9999 gives one interrupt every 10 000 ticks. Writing all zeros to the control word stops the timer. The interrupt stays pending until software writes a one to bit 30 of a separate acknowledge/status word. Reading that word shows the pending flag in the same bit position.

Top module: `tick_timer`

## Requirements
- R1: After reset the interrupt output is 0, the control word (byte offset 0x0) reads 0x00000000 and the status word (byte offset 0x4) reads 0x00000000.
- R2: Writing the control word with bit 31 = 1, bit 30 = 0 and count C = N-1 in bits [28:0] raises `irq` right after the edge that captures the N-th tick, and not before. A count of 0 fires on the first tick.
- R3: When a one-shot expiry happens, bit 31 of the control word reads 0 and the count holds at 0. Further ticks raise no new interrupt.
- R4: With bit 31 = 1 and bit 30 = 1, the timer reloads C after each expiry and fires every C+1 ticks, and bit 31 stays 1.
- R5: Writing 0x00000000 to the control word stops the timer. No interrupt follows, however many ticks arrive.
- R6: The count field read back from bits [28:0] drops by exactly one for each tick while it is enabled and nonzero. Without a tick, the count does not change.
- R7: Writing the status word with bit 30 = 1 clears a pending interrupt. A status write with bit 30 = 0 leaves the interrupt unchanged.
- R8: If an expiry and a clear happen in the same cycle, the interrupt stays set.
- R9: The control word reads back as {enable at bit 31, repeat at bit 30, 0 at bit 29, count at [28:0]}. The status word reads the pending flag at bit 30 and 0 in all other bits. Any other offset reads 0.
- R10: The largest count, 0x1FFFFFFF, is stored and read back without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pacing strobe that advances the counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Active-high level interrupt |

## Verification
A wrong count or a wrong reload value appears on `irq` at the expiry tick. It also appears on the count read-back one cycle after any tick. The bench compares both on every tick of a sweep over short intervals, in both modes. If the enable flag is not cleared after a one-shot, a second interrupt appears within C+1 ticks, and the read-back also shows it straight away. A broken acknowledge path shows up in the cycle right after the status write.

// File: rtl/tick_timer_pkg.sv
// Shared constants for the tick timer: register offsets and field positions.
// Assumes a 32-bit register word with byte addressing.
package tick_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int EN_BIT   = 31;
    localparam int MODE_BIT = 30;
    localparam int ACK_BIT  = 30;
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
endpackage

// File: rtl/tt_regs.sv
// Register decode and read-back mux for the tick timer.
// Assumes CNT_W <= 29, so that bit 29 of the control word is always reserved.
module tt_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 29,
    parameter int ADDR_W = 4
) (
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              en_q,
    input  logic              per_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              pend_q,
    output logic              wr_ctrl,
    output logic              wr_en,
    output logic              wr_per,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic              clr,
    output logic [DATA_W-1:0] reg_rdata
);
    logic sel_ctrl, sel_stat;
    logic [29-CNT_W:0] unused_bits;

    // Decode the offset into the two register selects.
    always_comb begin
        sel_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
        sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
    end

    // Split the write data into control fields and the acknowledge strobe.
    always_comb begin
        wr_ctrl = reg_we && sel_ctrl;
        wr_en   = reg_wdata[EN_BIT];
        wr_per  = reg_wdata[MODE_BIT];
        wr_cnt  = reg_wdata[CNT_W-1:0];
        clr     = reg_we && sel_stat && reg_wdata[ACK_BIT];
    end
    assign unused_bits = reg_wdata[29:CNT_W];

    // Build the read-back word for the selected register.
    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata[EN_BIT]    = en_q;
            reg_rdata[MODE_BIT]  = per_q;
            reg_rdata[CNT_W-1:0] = cnt_q;
        end else if (sel_stat) begin
            reg_rdata[ACK_BIT] = pend_q;
        end
    end
endmodule

// File: rtl/tt_counter.sv
// Down counter with reload, the enable flag and the repeat flag.
// Assumes tick is a single-cycle strobe. A control write wins over a tick in the same cycle.
module tt_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_ctrl,
    input  logic             wr_en,
    input  logic             wr_per,
    input  logic [CNT_W-1:0] wr_cnt,
    output logic             en_q,
    output logic             per_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    logic [CNT_W-1:0] reload_q;

    // An expiry is a tick that finds the enabled counter already at zero.
    always_comb expire = tick && en_q && (cnt_q == '0) && !wr_ctrl;

    // Load on write, otherwise count down, reload or stop on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            per_q    <= 1'b0;
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (wr_ctrl) begin
            en_q     <= wr_en;
            per_q    <= wr_per;
            cnt_q    <= wr_cnt;
            reload_q <= wr_cnt;
        end else if (tick && en_q) begin
            if (cnt_q == '0) begin
                if (per_q) cnt_q <= reload_q;
                else       en_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R3
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !per_q) |=> (!en_q && cnt_q == '0));
    // R4
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && per_q) |=> (en_q && cnt_q == reload_q));
    // R6
    tick_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en_q && cnt_q != '0 && !wr_ctrl) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_ctrl) |=> $stable(cnt_q));
endmodule

// File: rtl/tt_irq.sv
// Pending-interrupt flag: set by an expiry, cleared by an acknowledge. Set wins.
// Assumes expire and clr are single-cycle strobes.
module tt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    output logic pend_q
);
    // Hold the level interrupt until it is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (expire) pend_q <= 1'b1;
        else if (clr)    pend_q <= 1'b0;
    end

    // R2
    expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend_q);
    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !expire) |=> !pend_q);
    // R8
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !expire) |=> $stable(pend_q));
endmodule

// File: rtl/tick_timer.sv
// Top level of the tick timer: register decode, counter and interrupt flag.
// Assumes the tick strobe comes from outside and is synchronous to clk.
module tick_timer #(
    parameter int CNT_W  = 29,
    parameter int ADDR_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic             wr_ctrl, wr_en, wr_per, clr, expire;
    logic [CNT_W-1:0] wr_cnt, cnt_q;
    logic             en_q, per_q, pend_q;

    tt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .reg_we(reg_we), .reg_addr(reg_addr[ADDR_W-1:0]), .reg_wdata(reg_wdata),
        .en_q(en_q), .per_q(per_q), .cnt_q(cnt_q), .pend_q(pend_q),
        .wr_ctrl(wr_ctrl), .wr_en(wr_en), .wr_per(wr_per), .wr_cnt(wr_cnt),
        .clr(clr), .reg_rdata(reg_rdata)
    );

    tt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_ctrl(wr_ctrl), .wr_en(wr_en), .wr_per(wr_per), .wr_cnt(wr_cnt),
        .en_q(en_q), .per_q(per_q), .cnt_q(cnt_q), .expire(expire)
    );

    tt_irq irq_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr(clr), .pend_q(pend_q)
    );

    assign irq = pend_q;

    // R5
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !pend_q && !reg_we) |=> !irq);
endmodule

// File: tb/tick_timer_tb_top.sv
// Self-checking bench: sweeps short intervals in both modes and checks the edge cases.
module tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    tick_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One clock edge with the given write and tick inputs.
    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d, input logic t);
        reg_we = we; reg_addr = a; reg_wdata = d; tick = t;
        @(posedge clk); #1;
        reg_we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic clear_irq();
        step(1'b1, 4'h4, 32'h4000_0000, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(4'h0, rv); chk("R1 ctrl", rv, 32'd0);
        rd(4'h4, rv); chk("R1 stat", rv, 32'd0);

        // R2 R3 R6: one-shot sweep over intervals 1..8
        for (int n = 1; n <= 8; n++) begin
            step(1'b1, 4'h0, 32'h8000_0000 | 32'(n - 1), 1'b0);
            for (int k = 1; k <= n; k++) begin
                step(1'b0, 4'h0, '0, 1'b1);
                chk(k < n ? "R2 early irq" : "R2 expiry irq", {31'd0, irq}, {31'd0, k == n});
                rd(4'h0, rv);
                if (k < n) chk("R6 count", rv, 32'h8000_0000 | 32'(n - 1 - k));
                else       chk("R3 stopped", rv, 32'd0);
            end
            clear_irq();
            chk("R7 cleared", {31'd0, irq}, 32'd0);
            repeat (n + 2) step(1'b0, 4'h0, '0, 1'b1);
            chk("R3 no refire", {31'd0, irq}, 32'd0);
        end

        // R4: periodic sweep over intervals 1..5, three periods each
        for (int n = 1; n <= 5; n++) begin
            step(1'b1, 4'h0, 32'hC000_0000 | 32'(n - 1), 1'b0);
            for (int p = 0; p < 3; p++) begin
                for (int k = 1; k <= n; k++) begin
                    step(1'b0, 4'h0, '0, 1'b1);
                    chk("R4 period irq", {31'd0, irq}, {31'd0, k == n});
                end
                rd(4'h0, rv); chk("R4 reload", rv, 32'hC000_0000 | 32'(n - 1));
                clear_irq();
            end
        end

        // R5: write zero stops a running periodic timer
        step(1'b1, 4'h0, 32'hC000_0003, 1'b0);
        step(1'b0, 4'h0, '0, 1'b1);
        step(1'b0, 4'h0, '0, 1'b1);
        step(1'b1, 4'h0, 32'h0, 1'b0);
        repeat (10) step(1'b0, 4'h0, '0, 1'b1);
        chk("R5 no irq", {31'd0, irq}, 32'd0);
        rd(4'h0, rv); chk("R5 ctrl", rv, 32'd0);

        // R6: no tick, no change
        step(1'b1, 4'h0, 32'h8000_0010, 1'b0);
        repeat (4) step(1'b0, 4'h0, '0, 1'b0);
        rd(4'h0, rv); chk("R6 hold", rv, 32'h8000_0010);
        step(1'b1, 4'h0, 32'h0, 1'b0);

        // R7: acknowledge with bit 30 clear has no effect
        step(1'b1, 4'h0, 32'h8000_0000, 1'b0);
        step(1'b0, 4'h0, '0, 1'b1);
        step(1'b1, 4'h4, 32'hBFFF_FFFF, 1'b0);
        chk("R7 ignored ack", {31'd0, irq}, 32'd1);
        rd(4'h4, rv); chk("R9 stat pending", rv, 32'h4000_0000);
        clear_irq();
        chk("R7 ack", {31'd0, irq}, 32'd0);

        // R8: expiry in the same cycle as the clear keeps the interrupt
        step(1'b1, 4'h0, 32'hC000_0000, 1'b0);
        step(1'b0, 4'h0, '0, 1'b1);
        step(1'b1, 4'h4, 32'h4000_0000, 1'b1);
        chk("R8 set wins", {31'd0, irq}, 32'd1);
        step(1'b1, 4'h0, 32'h0, 1'b0);
        clear_irq();

        // R9 R10: read-back format and largest count
        step(1'b1, 4'h0, 32'h9FFF_FFFF, 1'b0);
        rd(4'h0, rv); chk("R10 max count", rv, 32'h9FFF_FFFF);
        step(1'b0, 4'h0, '0, 1'b1);
        rd(4'h0, rv); chk("R10 max minus one", rv, 32'h9FFF_FFFE);
        step(1'b1, 4'h0, 32'hFFFF_FFFF, 1'b0);
        rd(4'h0, rv); chk("R9 bit29 zero", rv, 32'hDFFF_FFFF);
        rd(4'h8, rv); chk("R9 unmapped", rv, 32'd0);
        step(1'b1, 4'h0, 32'h0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule